// File: doc/BRIEF.md
# Banked Performance Counter Controller

This block keeps four pairs of 32-bit event counters behind two software-visible registers: a 32-bit control register and a 64-bit counter-data register. A pair-select index in the control register decides which pair the event-select fields and the counter-data register refer to. Software therefore reaches every pair through the same two registers. It loops the index from zero up to the highest index that the control register reports.

Each counter picks one of sixteen event inputs through a 4-bit code and advances by one on every cycle in which that input is high. It counts only while the enable that matches the current privilege level is set. Two protect bits travel with every control write. The first keeps the stored event codes of the addressed pair. The second keeps the sticky overflow flags. With them set, software can change the index or the enables without touching the stored event codes or the overflow flags.

Top module: `pmu_bank`

## Requirements
- R1: After synchronous reset every counter is zero, all stored event codes are zero, the index, the enables, the protect bits and all overflow flags are zero, so the control register reads 32'h0300_0000.
- R2: The control-register index field (bits 1:0) chooses the addressed pair. Control reads return that pair's upper code in bits 7:4 and its lower code in bits 11:8. Counter-data reads and writes go to that pair.
- R3: On a control write with bit 14 set, the stored codes of the pair named by the written index stay unchanged. With bit 14 clear, they take the values in bits 7:4 (upper) and 11:8 (lower).
- R4: The overflow flags sit in control bits 23:16, with bit 16+2p for the lower counter of pair p and bit 17+2p for its upper counter. On a control write with bit 15 set the flags stay unchanged. With bit 15 clear the written bits replace them.
- R5: Bit 12 enables counting while `priv_mode` is 0, and bit 13 enables counting while `priv_mode` is 1. With the enable for the current level clear, no counter advances.
- R6: Control bits 27:24 always read the highest valid pair index, 3. Writes do not change this field.
- R7: The counter-data register is 64 bits wide: the upper counter sits in bits 63:32 and the lower counter in bits 31:0. A write loads both counters of the addressed pair, and the new value reads back on the next cycle. Writing zero clears the pair.
- R8: A counter with a nonzero code c adds one on each cycle in which `events[c]` is high and counting is enabled. Code 0 never counts, even when `events[0]` is high.
- R9: When a counter steps from all-ones to zero, its overflow flag is set. The flag stays set until a control write with bit 15 clear writes it to 0.
- R10: A counter-data write in the same cycle as an increment of the addressed pair wins: the counters hold exactly the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | Current privilege level, 1 = privileged |
| events | input | 16 | Event pulses, one bit per event code |
| ctrl_wr_en | input | 1 | Control-register write strobe |
| ctrl_wr_data | input | 32 | Control-register write value |
| ctrl_rd_data | output | 32 | Control-register read value |
| cnt_wr_en | input | 1 | Counter-data write strobe |
| cnt_wr_data | input | 64 | Counter-data write value, upper counter in 63:32 |
| cnt_rd_data | output | 64 | Addressed pair's counters, upper counter in 63:32 |

## Verification
The counting path is tried with table rows that each vary one factor: the privilege level against the two enables, both enables clear, code 0 while every event line is high, the two counters sharing one code, and event lines that match only one of the two codes. These rows tell a wrong enable choice apart from a broken event multiplexer and from a missing code-0 guard. Directed sequences then cover the rest. A counter is preloaded near the top so that it wraps, and the overflow flag is cleared under both settings of its protect bit. Protected and unprotected writes are made to one pair while other pairs hold their own codes. A counter-data write is made in the same cycle as a live event.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int NPAIRS  = 4;
    localparam int CNT_W   = 32;
    localparam int SEL_W   = 4;
    localparam int NEVT    = 1 << SEL_W;
    localparam int IDX_W   = $clog2(NPAIRS);
    localparam int NCNT    = 2 * NPAIRS;

    // Control register field positions
    localparam int F_IDX   = 0;
    localparam int F_HI    = 4;
    localparam int F_LO    = 8;
    localparam int F_UEN   = 12;
    localparam int F_PEN   = 13;
    localparam int F_SRO   = 14;
    localparam int F_ORO   = 15;
    localparam int F_OVF   = 16;
    localparam int F_MAX   = 24;
    localparam int MAX_W   = 4;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             en_user;
        logic             en_priv;
        logic             sel_ro;
        logic             ovf_ro;
        logic [NCNT-1:0]  ovf;
    } ctrl_state_t;

    function automatic logic [31:0] pack_ctrl(input ctrl_state_t s,
                                              input logic [SEL_W-1:0] hi,
                                              input logic [SEL_W-1:0] lo);
        logic [31:0] r;
        r = '0;
        r[F_IDX +: IDX_W] = s.idx;
        r[F_HI +: SEL_W]  = hi;
        r[F_LO +: SEL_W]  = lo;
        r[F_UEN]          = s.en_user;
        r[F_PEN]          = s.en_priv;
        r[F_SRO]          = s.sel_ro;
        r[F_ORO]          = s.ovf_ro;
        r[F_OVF +: NCNT]  = s.ovf;
        r[F_MAX +: MAX_W] = MAX_W'(NPAIRS - 1);
        return r;
    endfunction
endpackage

// File: rtl/pmu_ctrl_reg.sv
module pmu_ctrl_reg
    import pmu_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [31:0]                 wdata,
    input  logic [NCNT-1:0]             wrap,
    output logic [IDX_W-1:0]            idx,
    output logic                        en_user,
    output logic                        en_priv,
    output logic [NPAIRS-1:0][SEL_W-1:0] sel_hi,
    output logic [NPAIRS-1:0][SEL_W-1:0] sel_lo,
    output logic [31:0]                 rdata
);
    ctrl_state_t      st;
    ctrl_state_t      wr_f;
    logic [NCNT-1:0]  ovf_next;
    logic             unused_wbits;

    assign unused_wbits = ^{wdata[31:F_OVF+NCNT], wdata[F_HI-1:F_IDX+IDX_W]};

    always_comb begin
        wr_f.idx     = wdata[F_IDX +: IDX_W];
        wr_f.en_user = wdata[F_UEN];
        wr_f.en_priv = wdata[F_PEN];
        wr_f.sel_ro  = wdata[F_SRO];
        wr_f.ovf_ro  = wdata[F_ORO];
        wr_f.ovf     = wdata[F_OVF +: NCNT];
    end

    // Wrap events set flags even in the cycle of an unprotected write.
    always_comb begin
        ovf_next = st.ovf;
        if (wr_en && !wr_f.ovf_ro)
            ovf_next = wr_f.ovf;
        ovf_next = ovf_next | wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            sel_hi <= '0;
            sel_lo <= '0;
        end else begin
            if (wr_en) begin
                st.idx     <= wr_f.idx;
                st.en_user <= wr_f.en_user;
                st.en_priv <= wr_f.en_priv;
                st.sel_ro  <= wr_f.sel_ro;
                st.ovf_ro  <= wr_f.ovf_ro;
                if (!wr_f.sel_ro) begin
                    sel_hi[wr_f.idx] <= wdata[F_HI +: SEL_W];
                    sel_lo[wr_f.idx] <= wdata[F_LO +: SEL_W];
                end
            end
            st.ovf <= ovf_next;
        end
    end

    assign idx     = st.idx;
    assign en_user = st.en_user;
    assign en_priv = st.en_priv;
    assign rdata   = pack_ctrl(st, sel_hi[st.idx], sel_lo[st.idx]);
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int SW = SEL_W,
    parameter int NE = NEVT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NE-1:0] events,
    input  logic [SW-1:0] sel,
    input  logic          count_en,
    input  logic          ld,
    input  logic [CW-1:0] ld_val,
    output logic [CW-1:0] value,
    output logic          wrap
);
    logic inc;

    assign inc  = count_en && (sel != '0) && events[sel];
    assign wrap = inc && !ld && (value == {CW{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (ld)
            value <= ld_val;
        else if (inc)
            value <= value + CW'(1);
    end
endmodule

// File: rtl/pmu_bank.sv
module pmu_bank
    import pmu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                priv_mode,
    input  logic [NEVT-1:0]     events,
    input  logic                ctrl_wr_en,
    input  logic [31:0]         ctrl_wr_data,
    output logic [31:0]         ctrl_rd_data,
    input  logic                cnt_wr_en,
    input  logic [2*CNT_W-1:0]  cnt_wr_data,
    output logic [2*CNT_W-1:0]  cnt_rd_data
);
    logic [IDX_W-1:0]             idx;
    logic                         en_user;
    logic                         en_priv;
    logic                         count_en;
    logic [NPAIRS-1:0][SEL_W-1:0] sel_hi;
    logic [NPAIRS-1:0][SEL_W-1:0] sel_lo;
    logic [NCNT-1:0]              wrap;
    logic [NCNT-1:0][CNT_W-1:0]   cnt_val;

    pmu_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ctrl_wr_en),
        .wdata   (ctrl_wr_data),
        .wrap    (wrap),
        .idx     (idx),
        .en_user (en_user),
        .en_priv (en_priv),
        .sel_hi  (sel_hi),
        .sel_lo  (sel_lo),
        .rdata   (ctrl_rd_data)
    );

    assign count_en = priv_mode ? en_priv : en_user;

    // Counter c belongs to pair c/2; odd c is the upper half.
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
        localparam int PAIR = c / 2;
        localparam int HALF = c % 2;
        logic [SEL_W-1:0] sel;
        logic             ld;
        assign sel = (HALF == 1) ? sel_hi[PAIR] : sel_lo[PAIR];
        assign ld  = cnt_wr_en && (idx == IDX_W'(PAIR));
        pmu_counter u_cnt (
            .clk      (clk),
            .rst      (rst),
            .events   (events),
            .sel      (sel),
            .count_en (count_en),
            .ld       (ld),
            .ld_val   (cnt_wr_data[HALF*CNT_W +: CNT_W]),
            .value    (cnt_val[c]),
            .wrap     (wrap[c])
        );
    end

    assign cnt_rd_data = {cnt_val[{idx, 1'b1}], cnt_val[{idx, 1'b0}]};
endmodule

// File: rtl/pmu_bank_chk.sv
module pmu_bank_chk
    import pmu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               ctrl_wr_en,
    input logic [31:0]        ctrl_wr_data,
    input logic [31:0]        ctrl_rd_data,
    input logic               cnt_wr_en,
    input logic [2*CNT_W-1:0] cnt_wr_data,
    input logic [2*CNT_W-1:0] cnt_rd_data
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (cnt_rd_data == '0 && ctrl_rd_data[F_MAX-1:0] == '0));

    assert_sel_protect_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_en && ctrl_wr_data[F_SRO] &&
         ctrl_wr_data[F_IDX +: IDX_W] == ctrl_rd_data[F_IDX +: IDX_W])
        |=> ctrl_rd_data[F_LO+SEL_W-1:F_HI] == $past(ctrl_rd_data[F_LO+SEL_W-1:F_HI]));

    assert_ovf_protect_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr_en && ctrl_wr_data[F_ORO])
        |=> (ctrl_rd_data[F_OVF +: NCNT] & $past(ctrl_rd_data[F_OVF +: NCNT]))
            == $past(ctrl_rd_data[F_OVF +: NCNT]));

    assert_no_count_R5: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_rd_data[F_UEN] && !ctrl_rd_data[F_PEN] && !ctrl_wr_en && !cnt_wr_en)
        |=> $stable(cnt_rd_data));

    assert_max_index_R6: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd_data[F_MAX +: MAX_W] == MAX_W'(NPAIRS - 1));

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (cnt_wr_en && !ctrl_wr_en) |=> cnt_rd_data == $past(cnt_wr_data));
endmodule

bind pmu_bank pmu_bank_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .ctrl_wr_en   (ctrl_wr_en),
    .ctrl_wr_data (ctrl_wr_data),
    .ctrl_rd_data (ctrl_rd_data),
    .cnt_wr_en    (cnt_wr_en),
    .cnt_wr_data  (cnt_wr_data),
    .cnt_rd_data  (cnt_rd_data)
);

// File: tb/pmu_bank_tb_top.sv
`timescale 1ns/1ps
module pmu_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        priv_mode = 1'b0;
    logic [15:0] events = '0;
    logic        ctrl_wr_en = 1'b0;
    logic [31:0] ctrl_wr_data = '0;
    logic [31:0] ctrl_rd_data;
    logic        cnt_wr_en = 1'b0;
    logic [63:0] cnt_wr_data = '0;
    logic [63:0] cnt_rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pmu_bank dut_i (
        .clk(clk), .rst(rst), .priv_mode(priv_mode), .events(events),
        .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd_data(ctrl_rd_data),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_data(cnt_wr_data), .cnt_rd_data(cnt_rd_data)
    );

    typedef struct packed {
        logic [3:0]  hi;
        logic [3:0]  lo;
        logic        ue;
        logic        pe;
        logic        pm;
        logic [15:0] ev;
        logic [7:0]  n;
        logic [31:0] exp_hi;
        logic [31:0] exp_lo;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{4'd1, 4'd2, 1'b1, 1'b0, 1'b0, 16'h0006, 8'd5, 32'd5, 32'd5},
        '{4'd1, 4'd2, 1'b1, 1'b0, 1'b1, 16'h0006, 8'd5, 32'd0, 32'd0},
        '{4'd1, 4'd2, 1'b0, 1'b1, 1'b1, 16'h0002, 8'd5, 32'd5, 32'd0},
        '{4'd0, 4'd15, 1'b1, 1'b1, 1'b0, 16'hFFFF, 8'd3, 32'd0, 32'd3},
        '{4'd3, 4'd4, 1'b0, 1'b0, 1'b0, 16'hFFFF, 8'd4, 32'd0, 32'd0},
        '{4'd7, 4'd7, 1'b1, 1'b1, 1'b1, 16'h0080, 8'd7, 32'd7, 32'd7},
        '{4'd9, 4'd8, 1'b1, 1'b0, 1'b0, 16'h0100, 8'd2, 32'd0, 32'd2}
    };

    function automatic logic [31:0] mk(input int idx, input int hi, input int lo,
                                       input bit ue, input bit pe, input bit sro,
                                       input bit oro, input logic [7:0] ovf);
        logic [31:0] w;
        w = '0;
        w[1:0]   = 2'(idx);
        w[7:4]   = 4'(hi);
        w[11:8]  = 4'(lo);
        w[12]    = ue;
        w[13]    = pe;
        w[14]    = sro;
        w[15]    = oro;
        w[23:16] = ovf;
        return w;
    endfunction

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [31:0] w);
        @(negedge clk);
        ctrl_wr_en   = 1'b1;
        ctrl_wr_data = w;
        @(negedge clk);
        ctrl_wr_en   = 1'b0;
    endtask

    task automatic cnt_write(input logic [63:0] v);
        @(negedge clk);
        cnt_wr_en   = 1'b1;
        cnt_wr_data = v;
        @(negedge clk);
        cnt_wr_en   = 1'b0;
    endtask

    task automatic run_events(input int n, input logic [15:0] ev);
        @(negedge clk);
        events = ev;
        repeat (n) @(negedge clk);
        events = '0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 / R6: reset state
        check(64'(ctrl_rd_data), 64'h0300_0000, "R1 control after reset");
        check(cnt_rd_data, 64'h0, "R1 counters after reset");
        check(64'(ctrl_rd_data[27:24]), 64'd3, "R6 highest pair index");

        // R5 / R8 table walk on pair 0
        for (int i = 0; i < NV; i++) begin
            ctrl_write(mk(0, VECS[i].hi, VECS[i].lo, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00));
            cnt_write(64'h0);
            priv_mode = VECS[i].pm;
            ctrl_write(mk(0, 0, 0, VECS[i].ue, VECS[i].pe, 1'b1, 1'b1, 8'h00));
            run_events(int'(VECS[i].n), VECS[i].ev);
            ctrl_write(mk(0, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00));
            check(cnt_rd_data, {VECS[i].exp_hi, VECS[i].exp_lo}, "R5 R8 count vector");
        end
        priv_mode = 1'b0;

        // R2 / R3: per-pair event codes and their protect bit
        ctrl_write(mk(2, 5, 6, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00));
        ctrl_write(mk(1, 3, 4, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00));
        check(64'(ctrl_rd_data[11:0]), 64'h431, "R2 pair 1 codes");
        ctrl_write(mk(2, 9, 9, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00));
        check(64'(ctrl_rd_data[11:0]), 64'h652, "R3 protected codes kept");
        ctrl_write(mk(2, 9, 9, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00));
        check(64'(ctrl_rd_data[11:0]), 64'h992, "R3 unprotected codes replaced");

        // R7: data register addresses the selected pair
        ctrl_write(mk(3, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00));
        cnt_write(64'hAAAA_0001_5555_0002);
        check(cnt_rd_data, 64'hAAAA_0001_5555_0002, "R7 load pair 3");
        ctrl_write(mk(0, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00));
        check(cnt_rd_data, 64'h0000_0000_0000_0002, "R2 R7 pair 0 untouched");
        ctrl_write(mk(3, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00));
        cnt_write(64'h0);
        check(cnt_rd_data, 64'h0, "R7 zero write clears pair");

        // R9 / R4: wrap sets a sticky flag, protect bit guards it
        ctrl_write(mk(1, 0, 1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00));
        cnt_write({32'h0, 32'hFFFF_FFFE});
        ctrl_write(mk(1, 0, 0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00));
        run_events(2, 16'h0002);
        check(cnt_rd_data, 64'h0, "R9 lower counter wrapped");
        check(64'(ctrl_rd_data[23:16]), 64'h04, "R9 overflow flag pair 1 lower");
        ctrl_write(mk(1, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00));
        check(64'(ctrl_rd_data[23:16]), 64'h04, "R4 protected flag kept");
        ctrl_write(mk(1, 0, 0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00));
        check(64'(ctrl_rd_data[23:16]), 64'h00, "R4 unprotected write clears flag");

        // R10: load and increment in the same cycle
        ctrl_write(mk(1, 0, 0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00));
        @(negedge clk);
        events      = 16'h0002;
        cnt_wr_en   = 1'b1;
        cnt_wr_data = {32'd0, 32'd100};
        @(negedge clk);
        events      = '0;
        cnt_wr_en   = 1'b0;
        ctrl_write(mk(1, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00));
        check(cnt_rd_data, {32'd0, 32'd100}, "R10 load beats increment");
        check(64'(ctrl_rd_data[27:24]), 64'd3, "R6 index field after writes");

        done = 1'b1;
        finish_run();
    end
endmodule